// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches virtual-to-physical page translations so that address translation can usually skip a page-table fetch. It holds 16 translations, arranged as 4 sets of 4 ways. Each line stores one translation: a tag, a physical page number and a valid flag. The set and the tag both come from the virtual page number.

A lookup port takes an 8-bit virtual page number. In the same cycle it returns a hit flag and the 6-bit physical page number. A fill port installs a mapping, usually after a miss has been resolved elsewhere. The fill chooses a way inside the selected set: first a way that already holds the same page, then the lowest free way, and last a per-set rotating victim. A flush input drops every translation in one cycle, for example on a context switch.

Top module: `xlat_tlb`

## Requirements
- R1: The set is given by VPN bits [1:0], and the tag is VPN bits [7:2]. For example, VPN 0x0F maps to set 3 with tag 0x03. A VPN with the same tag in another set, or with another tag in the same set, does not hit on that entry.
- R2: When the selected set holds a valid entry with a matching tag, `look_hit` is 1 and `look_ppn` carries that entry's stored page number. Both are combinational in the same cycle as `look_vpn`.
- R3: On a miss, `look_hit` is 0 and `look_ppn` is 0.
- R4: A fill with no matching entry in its set goes to the lowest-numbered invalid way of that set.
- R5: A fill into a set whose 4 ways are all valid, with no matching tag, replaces the way named by that set's rotating pointer. The pointer then advances by one, modulo 4. Reset sets every pointer to way 0. A flush leaves the pointers unchanged.
- R6: A fill whose VPN is already present only rewrites that entry's page number. It displaces no other entry and does not move the pointer.
- R7: While `flush` is 1, every lookup misses. From the next cycle, every entry is invalid.
- R8: After reset, every entry is invalid, so all lookups miss.
- R9: A fill becomes visible to lookups from the cycle after it is accepted. A lookup in the same cycle sees the contents from before the fill.
- R10: When `fill_en` and `flush` are both 1, the flush wins and the fill is discarded.
- R11: A fill changes only the set selected by its own VPN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_vpn | input | 8 | Virtual page number to translate |
| look_hit | output | 1 | Translation found (combinational) |
| look_ppn | output | 6 | Physical page number on a hit, 0 on a miss |
| fill_en | input | 1 | Install or update a translation this cycle |
| fill_vpn | input | 8 | Virtual page number of the fill |
| fill_ppn | input | 6 | Physical page number of the fill |
| flush | input | 1 | Invalidate all translations |

## Verification
Directed runs fill one set past its capacity, which shows that free ways are taken first and that victims then rotate. They also rewrite a page that is already present, which tells an in-place update apart from an eviction. Lookups that share a tag but differ in set, or share a set but differ in tag, separate the index bits from the tag bits. Flush is applied alone, with a lookup, and together with a fill, and a long random run over a narrow VPN range exercises crowded sets and mixed operations.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  // Where a fill lands inside its set
  typedef enum logic [1:0] {
    SRC_SAME = 2'd0,  // way already holding this tag
    SRC_FREE = 2'd1,  // lowest invalid way
    SRC_ROT  = 2'd2   // rotating victim pointer
  } fill_src_e;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned WAYS  = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]         valid,
  input  logic [WAYS-1:0]         same,
  input  logic [WAY_W-1:0]        rot_ptr,
  output logic [WAY_W-1:0]        way,
  output xlat_tlb_pkg::fill_src_e src
);
  always_comb begin
    way = rot_ptr;
    src = xlat_tlb_pkg::SRC_ROT;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        way = WAY_W'(w);
        src = xlat_tlb_pkg::SRC_FREE;
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (same[w]) begin
        way = WAY_W'(w);
        src = xlat_tlb_pkg::SRC_SAME;
      end
    end
  end
endmodule

// File: rtl/tlb_set.sv
module tlb_set #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned PPN_W = 6,
  parameter int unsigned WAYS  = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn
);
  logic [WAYS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [PPN_W-1:0] ppn_q [WAYS];
  logic [WAY_W-1:0] rot_q;
  logic [WAYS-1:0]  rd_m, wr_m;
  logic [WAY_W-1:0] v_way;
  xlat_tlb_pkg::fill_src_e v_src;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign rd_m[w] = vld_q[w] && (tag_q[w] == rd_tag);
    assign wr_m[w] = vld_q[w] && (tag_q[w] == wr_tag);
  end

  // Tags are never duplicated, so at most one way matches
  always_comb begin
    rd_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_m[w]) rd_ppn = rd_ppn | ppn_q[w];
    end
  end
  assign rd_hit = |rd_m;

  tlb_victim #(.WAYS(WAYS)) i_victim (
    .valid   (vld_q),
    .same    (wr_m),
    .rot_ptr (rot_q),
    .way     (v_way),
    .src     (v_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rot_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[v_way] <= 1'b1;
      if (v_src == xlat_tlb_pkg::SRC_ROT)
        rot_q <= (rot_q == WAY_W'(WAYS - 1)) ? '0 : rot_q + 1'b1;
    end
  end

  // Payload storage without reset; the valid bits qualify every read
  always_ff @(posedge clk) begin
    if (wr_en && !flush && !rst) begin
      tag_q[v_way] <= wr_tag;
      ppn_q[v_way] <= wr_ppn;
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 6,
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output logic [PPN_W-1:0] look_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - SET_W;

  logic [SET_W-1:0] look_set, fill_set;
  logic [TAG_W-1:0] look_tag, fill_tag;
  logic             set_hit [SETS];
  logic [PPN_W-1:0] set_ppn [SETS];

  assign look_set = look_vpn[SET_W-1:0];
  assign look_tag = look_vpn[VPN_W-1:SET_W];
  assign fill_set = fill_vpn[SET_W-1:0];
  assign fill_tag = fill_vpn[VPN_W-1:SET_W];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    tlb_set #(.TAG_W(TAG_W), .PPN_W(PPN_W), .WAYS(WAYS)) i_set (
      .clk    (clk),
      .rst    (rst),
      .flush  (flush),
      .rd_tag (look_tag),
      .rd_hit (set_hit[s]),
      .rd_ppn (set_ppn[s]),
      .wr_en  (fill_en && (fill_set == SET_W'(s))),
      .wr_tag (fill_tag),
      .wr_ppn (fill_ppn)
    );
  end

  assign look_hit = set_hit[look_set] && !flush;
  assign look_ppn = look_hit ? set_ppn[look_set] : '0;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [VPN_W-1:0] look_vpn,
  input logic             look_hit,
  input logic [PPN_W-1:0] look_ppn,
  input logic             fill_en,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             flush
);
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !look_hit |-> (look_ppn == '0));

  p_flush_miss_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> !look_hit);

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !look_hit);

  p_reset_empty_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !look_hit);

  p_fill_visible_r9: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=>
      ((look_vpn == $past(fill_vpn) && !flush) |->
        (look_hit && look_ppn == $past(fill_ppn))));
endmodule

bind xlat_tlb xlat_tlb_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) i_xlat_tlb_chk (
  .clk(clk), .rst(rst), .look_vpn(look_vpn), .look_hit(look_hit),
  .look_ppn(look_ppn), .fill_en(fill_en), .fill_vpn(fill_vpn),
  .fill_ppn(fill_ppn), .flush(flush)
);

// File: tb/test_xlat_tlb.sv
module test_xlat_tlb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] look_vpn = '0;
  logic       look_hit;
  logic [5:0] look_ppn;
  logic       fill_en = 1'b0;
  logic [7:0] fill_vpn = '0;
  logic [5:0] fill_ppn = '0;
  logic       flush = 1'b0;

  int checks = 0;
  int errors = 0;

  // Behavioural model: slot contents per set (-1 = empty) and victim pointers
  int mv [4][4];
  int mp [4][4];
  int mrot [4];

  always #5 clk = ~clk;

  xlat_tlb i_xlat_tlb (
    .clk(clk), .rst(rst), .look_vpn(look_vpn), .look_hit(look_hit),
    .look_ppn(look_ppn), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .flush(flush)
  );

  task automatic model_clear(input bit all);
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) mv[s][w] = -1;
      if (all) mrot[s] = 0;
    end
  endtask

  task automatic model_fill(input int v, input int p);
    int s, slot;
    s = v % 4;
    slot = -1;
    for (int w = 0; w < 4; w++) if (slot < 0 && mv[s][w] == v) slot = w;
    if (slot < 0)
      for (int w = 0; w < 4; w++) if (slot < 0 && mv[s][w] < 0) slot = w;
    if (slot < 0) begin
      slot = mrot[s];
      mrot[s] = (mrot[s] + 1) % 4;
    end
    mv[s][slot] = v;
    mp[s][slot] = p;
  endtask

  task automatic step(input logic [7:0] lv, input logic fe, input logic [7:0] fv,
                      input logic [5:0] fp, input logic fl, input string req);
    bit eh;
    int ep, s;
    @(negedge clk);
    look_vpn = lv; fill_en = fe; fill_vpn = fv; fill_ppn = fp; flush = fl;
    #4;
    eh = 0; ep = 0; s = lv % 4;
    if (!fl)
      for (int w = 0; w < 4; w++)
        if (mv[s][w] == int'(lv)) begin eh = 1; ep = mp[s][w]; end
    checks++;
    if (look_hit !== eh || int'(look_ppn) != ep) begin
      errors++;
      $display("FAIL %s vpn=%h actual hit=%b ppn=%h expected hit=%b ppn=%h",
               req, lv, look_hit, look_ppn, eh, ep[5:0]);
    end
    @(posedge clk);
    #1;
    if (fl) model_clear(0);
    else if (fe) model_fill(int'(fv), int'(fp));
  endtask

  task automatic look(input logic [7:0] lv, input string req);
    step(lv, 1'b0, 8'h00, 6'h00, 1'b0, req);
  endtask

  task automatic fill(input logic [7:0] fv, input logic [5:0] fp, input string req);
    step(8'h00, 1'b1, fv, fp, 1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear(1);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R8: empty after reset
    look(8'h0F, "R8 reset");
    look(8'h00, "R8 reset");
    look(8'hFF, "R8 reset");

    // R9: same-cycle lookup sees old contents, then hit; R1/R2 field split
    step(8'h0F, 1'b1, 8'h0F, 6'h0D, 1'b0, "R9 same cycle");
    look(8'h0F, "R2 hit");
    look(8'h0E, "R1 other set same tag");
    look(8'h1F, "R1 same set other tag");
    look(8'h03, "R3 miss ppn zero");

    // R4: free ways taken in order, R5 rotation after full
    fill(8'h13, 6'h11, "R4 free way");
    fill(8'h23, 6'h12, "R4 free way");
    fill(8'h33, 6'h13, "R4 free way");
    look(8'h33, "R4 filled");
    look(8'h0F, "R4 kept");
    fill(8'h43, 6'h14, "R5 evict");
    look(8'h0F, "R5 way0 evicted");
    look(8'h43, "R5 new hit");
    look(8'h13, "R5 way1 kept");
    fill(8'h53, 6'h15, "R5 evict");
    look(8'h13, "R5 way1 evicted");

    // R6: in-place update, pointer not moved
    fill(8'h23, 6'h2A, "R6 update");
    look(8'h23, "R6 new ppn");
    look(8'h33, "R6 neighbour kept");
    look(8'h43, "R6 neighbour kept");
    look(8'h53, "R6 neighbour kept");
    fill(8'h63, 6'h16, "R6 pointer held");
    look(8'h23, "R6 pointer held");
    look(8'h33, "R6 pointer held");

    // R11: other sets untouched
    fill(8'h40, 6'h01, "R11 set0");
    fill(8'h41, 6'h02, "R11 set1");
    look(8'h40, "R11 set0 hit");
    look(8'h41, "R11 set1 hit");
    look(8'h63, "R11 set3 kept");
    look(8'h42, "R11 set2 empty");

    // R7: lookup during flush misses, then all empty
    step(8'h40, 1'b0, 8'h00, 6'h00, 1'b1, "R7 flush same cycle");
    look(8'h40, "R7 after flush");
    look(8'h63, "R7 after flush");

    // R10: flush beats fill
    step(8'h00, 1'b1, 8'h77, 6'h3F, 1'b1, "R10 flush with fill");
    look(8'h77, "R10 fill dropped");

    // R5: pointers survive flush
    fill(8'h07, 6'h21, "R5 refill");
    fill(8'h17, 6'h22, "R5 refill");
    fill(8'h27, 6'h23, "R5 refill");
    fill(8'h37, 6'h24, "R5 refill");
    fill(8'h47, 6'h25, "R5 pointer after flush");
    look(8'h07, "R5 pointer after flush");
    look(8'h17, "R5 pointer after flush");
    look(8'h27, "R5 pointer after flush");
    look(8'h37, "R5 pointer after flush");
    look(8'h47, "R5 pointer after flush");

    // R2: random mixed traffic on a narrow VPN range
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] lv, fv;
      lv = 8'($urandom_range(0, 31));
      fv = 8'($urandom_range(0, 31));
      step(lv, ($urandom_range(0, 2) == 0), fv, 6'($urandom),
           ($urandom_range(0, 99) == 0), "R2 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule